// File: doc/BRIEF.md
# Tagged Conversion Result Queue

This block holds converted analog samples between a scan sequencer and a byte-wide host register port. Each arriving 16-bit word carries a 12-bit conversion value in its upper twelve bits and a 4-bit input-channel tag in its lower four bits. Words are taken from a single-cycle write strobe, but only while the host has switched capture on. They are held in a first-in first-out store 1024 words deep.

The host drains the store one byte at a time. It reads the low byte of the oldest word first and then the high byte, and the high-byte read retires the word. A status byte reports empty, half-full and overflow. When the fill level first reaches half of the depth, the block raises an interrupt, and the host answers by draining a fixed batch of 512 words. A word that arrives while the store is full is dropped and sets a sticky overflow flag. Only a flush clears that flag.

Top module: `tsfifo_host`

## Requirements
- R1: After reset, the status byte reads 0x01 (empty only), the interrupt output is low, and capture is off, so a strobed word is not stored until the host enables capture.
- R2: While capture is off, an asserted sample strobe leaves the stored contents and the fill level unchanged.
- R3: A read at offset 23 returns bits [7:0] of the oldest stored word, and a read at offset 24 returns bits [15:8]. The conversion value is bits [15:4] of the reassembled word and the channel tag is bits [3:0].
- R4: Only a read strobe at offset 24 retires the oldest word. A read strobe at offset 23 leaves it in place. Words come out in arrival order. Data reads from an empty store return 0x00 and retire nothing.
- R5: The status byte at offset 25 has bit 0 set when the store is empty, bit 1 set when it holds at least 512 words, and bit 2 set when the overflow flag is set. Bits 7:3 read zero.
- R6: A word strobed while capture is on and 1024 words are held is discarded and sets the overflow flag. The flag stays set through reads and draining until a flush.
- R7: Any write to offset 25 empties the store and clears the overflow flag in the same cycle. A strobe in that cycle is not stored.
- R8: The interrupt output goes high one clock after the fill level first reaches 512, on the rising edge of the half-full condition only. It stays high until it is cleared, and it does not fire again while the level stays at or above 512.
- R9: Writing a byte with bit 0 set to offset 6 turns capture on, and writing bit 0 clear turns it off. Turning capture off keeps the stored words readable.
- R10: Any write to offset 20 drops the interrupt output on the next clock, unless a new half-full edge occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | One-cycle strobe that offers a tagged word |
| smp_word | input | 16 | Tagged word: conversion value [15:4], channel tag [3:0] |
| bus_addr | input | 5 | Host register offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe (a read at offset 24 retires a word) |
| bus_rdata | output | 8 | Read data for the offset on bus_addr, combinational |
| irq | output | 1 | Half-full interrupt, held until cleared |

## Verification
A wrong read or write pointer shows up at the first data read after it goes wrong, as a byte that does not match the word strobed in that position. A level counter that drifts shows up as a status byte whose empty or half-full bit differs from the count the bench keeps, within one clock of the stray push or pop. A broken edge detector shows up as an interrupt that arrives late, arrives twice, or comes back after a clear while the store stays above half. The bench catches this at the cycle after the 512th word and again after draining one batch. A lost sticky flag shows up as bit 2 dropping while the store is drained after an overflow.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int BUS_AW = 5;
  localparam int BUS_DW = 8;

  localparam logic [BUS_AW-1:0] OFS_CAPTURE = 5'd6;
  localparam logic [BUS_AW-1:0] OFS_IRQ_CLR = 5'd20;
  localparam logic [BUS_AW-1:0] OFS_DATA_LO = 5'd23;
  localparam logic [BUS_AW-1:0] OFS_DATA_HI = 5'd24;
  localparam logic [BUS_AW-1:0] OFS_STATUS  = 5'd25;

  localparam int STS_EMPTY = 0;
  localparam int STS_HALF  = 1;
  localparam int STS_OVF   = 2;

  typedef struct packed {
    logic empty;
    logic half;
    logic ovf;
  } tsf_flags_t;
endpackage

// File: rtl/tsf_rst_sync.sv
module tsf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH  = 1024,
  parameter int WORD_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              flush,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] head_word,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              half
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_HALF = LVL_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr, rd_ptr_d;
  logic [LVL_W-1:0]  level_d;
  logic              push_ok, pop_ok;

  assign full  = (level == LVL_FULL);
  assign empty = (level == '0);
  assign half  = (level >= LVL_HALF);

  always_comb begin
    push_ok = push_req && !full && !flush;
    pop_ok  = pop_req && !empty && !flush;
  end

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    level_d  = level;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (push_ok) wr_ptr_d = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr_d = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level_d = level + 1'b1;
        2'b01:   level_d = level - 1'b1;
        default: level_d = level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      level  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_word;
  end

  assign head_word = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/tsf_events.sv
module tsf_events (
  input  logic clk,
  input  logic rst_n,
  input  logic half,
  input  logic ovf_event,
  input  logic flush,
  input  logic irq_clr,
  output logic ovf_flag,
  output logic irq
);
  logic half_q, half_d;
  logic ovf_d, irq_d;
  logic half_rise;

  always_comb begin
    half_rise = half && !half_q;
    half_d    = half;
    ovf_d     = flush ? 1'b0 : (ovf_flag || ovf_event);
    if (half_rise)    irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q   <= 1'b0;
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      half_q   <= half_d;
      ovf_flag <= ovf_d;
      irq      <= irq_d;
    end
  end
endmodule

// File: rtl/tsf_host_regs.sv
module tsf_host_regs
  import tsf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] head_word,
  input  tsf_flags_t        flags,
  output logic              capture_en,
  output logic              flush,
  output logic              irq_clr,
  output logic              pop_req,
  output logic [BUS_DW-1:0] bus_rdata
);
  logic capture_d;
  logic wr_capture;

  always_comb begin
    wr_capture = bus_wr && (bus_addr == OFS_CAPTURE);
    flush      = bus_wr && (bus_addr == OFS_STATUS);
    irq_clr    = bus_wr && (bus_addr == OFS_IRQ_CLR);
    pop_req    = bus_rd && (bus_addr == OFS_DATA_HI);
    capture_d  = wr_capture ? bus_wdata[0] : capture_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capture_en <= 1'b0;
    else        capture_en <= capture_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA_LO: bus_rdata = head_word[7:0];
      OFS_DATA_HI: bus_rdata = head_word[15:8];
      OFS_STATUS: begin
        bus_rdata[STS_EMPTY] = flags.empty;
        bus_rdata[STS_HALF]  = flags.half;
        bus_rdata[STS_OVF]   = flags.ovf;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsfifo_host.sv
module tsfifo_host
  import tsf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int WORD_W = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_word,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq
);
  logic              rst_sync_n;
  logic              capture_en;
  logic              flush, irq_clr, pop_req;
  logic              push_req, ovf_event;
  logic [WORD_W-1:0] head_word;
  logic [LVL_W-1:0]  level;
  logic              full, empty, half;
  logic              ovf_flag;
  tsf_flags_t        flags;

  tsf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    push_req    = smp_valid && capture_en;
    ovf_event   = push_req && full && !flush;
    flags.empty = empty;
    flags.half  = half;
    flags.ovf   = ovf_flag;
  end

  tsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .push_req(push_req), .pop_req(pop_req), .flush(flush),
    .wr_word(smp_word), .head_word(head_word), .level(level),
    .full(full), .empty(empty), .half(half)
  );

  tsf_events u_events (
    .clk(clk), .rst_n(rst_sync_n),
    .half(half), .ovf_event(ovf_event), .flush(flush), .irq_clr(irq_clr),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  tsf_host_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .head_word(head_word), .flags(flags),
    .capture_en(capture_en), .flush(flush), .irq_clr(irq_clr), .pop_req(pop_req),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/tsfifo_host_chk.sv
module tsfifo_host_chk
  import tsf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              capture_en,
  input logic [LVL_W-1:0]  level,
  input logic              half,
  input logic              ovf_flag,
  input logic              irq
);
  logic wr_clr, wr_flush, rd_hi, rd_lo;
  assign wr_clr   = bus_wr && (bus_addr == OFS_IRQ_CLR);
  assign wr_flush = bus_wr && (bus_addr == OFS_STATUS);
  assign rd_hi    = bus_rd && (bus_addr == OFS_DATA_HI);
  assign rd_lo    = bus_rd && (bus_addr == OFS_DATA_LO);

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_clr |=> irq); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !half |=> !irq); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !wr_flush |=> ovf_flag); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flush |=> (level == '0) && !ovf_flag); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en && !wr_flush && !rd_hi |=> $stable(level)); // R2
  AST_LO_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !(smp_valid && capture_en) && !wr_flush |=> $stable(level)); // R4
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R6
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(DEPTH)) && !rd_hi && !wr_flush |=> level == LVL_W'(DEPTH)); // R6
endmodule

bind tsfifo_host tsfifo_host_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .smp_valid(smp_valid),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .capture_en(capture_en), .level(level), .half(half),
  .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/tsfifo_host_test.sv
module tsfifo_host_test;
  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_word;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [4:0] A_CAP = 5'd6, A_CLR = 5'd20, A_LO = 5'd23, A_HI = 5'd24, A_STS = 5'd25;

  // {word, expected conversion value, expected tag}
  localparam logic [31:0] VEC [8] = '{
    {16'hABC7, 12'hABC, 4'h7}, {16'h0000, 12'h000, 4'h0},
    {16'hFFFF, 12'hFFF, 4'hF}, {16'h800F, 12'h800, 4'hF},
    {16'h7FF1, 12'h7FF, 4'h1}, {16'h5A5A, 12'h5A5, 4'hA},
    {16'hA5A5, 12'hA5A, 4'h5}, {16'h0013, 12'h001, 4'h3}
  };

  tsfifo_host uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    smp_valid = 1'b1; smp_word = w;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic status(output logic [7:0] s);
    bus_addr = A_STS; #1 s = bus_rdata;
  endtask

  task automatic read_lo(output logic [7:0] b);
    bus_addr = A_LO; bus_rd = 1'b1; #1 b = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_hi(output logic [7:0] b);
    bus_addr = A_HI; bus_rd = 1'b1; #1 b = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] lo, hi;
    read_lo(lo);
    read_hi(hi);
    w = {hi, lo};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] fill_word(input int i);
    return {i[11:0], i[3:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  s, b0, b1;
    logic [15:0] w;
    smp_valid = 0; smp_word = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0; bus_rd = 0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    status(s);  check("R1 status", s, 8'h01);
    check("R1 irq", irq, 1'b0);
    push(16'h1234); status(s); check("R1 capture off after reset", s, 8'h01);

    // R2: strobes with capture off are ignored
    push(16'h4321); push(16'h9999); status(s); check("R2 disabled strobe", s, 8'h01);
    read_word(w); check("R4 empty read gives zero", w, 16'h0000);

    // R9: enable, then stream the vector table
    bwrite(A_CAP, 8'h01);
    for (int i = 0; i < 8; i++) push(VEC[i][31:16]);
    status(s); check("R5 partial fill status", s, 8'h00);
    for (int i = 0; i < 8; i++) begin
      read_lo(b0); read_lo(b1);
      check("R4 low read does not retire", b1, b0);
      read_hi(b1);
      w = {b1, b0};
      check("R3 conversion value", w[15:4], VEC[i][15:4]);
      check("R3 channel tag", w[3:0], VEC[i][3:0]);
    end
    status(s); check("R4 drained to empty", s, 8'h01);

    // R9: disable keeps contents, blocks new words
    push(16'h1111); push(16'h2222);
    bwrite(A_CAP, 8'h00);
    push(16'h3333);
    read_word(w); check("R9 kept word 0", w, 16'h1111);
    read_word(w); check("R9 kept word 1", w, 16'h2222);
    status(s); check("R9 disabled word not stored", s, 8'h01);
    bwrite(A_CAP, 8'hFF);

    // R5/R8: half-full edge
    for (int i = 0; i < 511; i++) push(fill_word(i));
    status(s); check("R5 511 words not half", s, 8'h00);
    push(fill_word(511));
    status(s); check("R5 512 words half", s, 8'h02);
    check("R8 irq not yet", irq, 1'b0);
    @(negedge clk);
    check("R8 irq one clock later", irq, 1'b1);

    // R6: fill to full, then overflow
    for (int i = 512; i < 1024; i++) push(fill_word(i));
    status(s); check("R6 full no overflow yet", s, 8'h02);
    push(16'hDEAD);
    status(s); check("R6 overflow flag", s, 8'h06);
    check("R8 irq held", irq, 1'b1);

    // R10: clear interrupt
    bwrite(A_CLR, 8'h00);
    check("R10 irq cleared", irq, 1'b0);

    // drain a batch of 512
    for (int i = 0; i < 512; i++) begin
      read_word(w);
      if (i == 0 || i == 511) check("R4 batch order", w, fill_word(i));
    end
    status(s); check("R6 sticky after drain", s, 8'h06);
    check("R8 no refire while above half", irq, 1'b0);
    for (int i = 512; i < 1024; i++) begin
      read_word(w);
      if (i == 1023) check("R6 overflowed word discarded", w, fill_word(1023));
    end
    status(s); check("R6 sticky when empty", s, 8'h05);

    // R7: flush
    push(16'h0101); push(16'h0202);
    bwrite(A_STS, 8'h00);
    status(s); check("R7 flush empties and clears", s, 8'h01);
    read_word(w); check("R7 flushed data gone", w, 16'h0000);

    // R8: second edge after flush re-arms
    for (int i = 0; i < 512; i++) push(fill_word(i));
    @(negedge clk);
    check("R8 second edge fires", irq, 1'b1);

    // R1: reset mid-run
    do_reset();
    status(s); check("R1 reset clears store", s, 8'h01);
    check("R1 reset clears irq", irq, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule